// File: doc/BRIEF.md
# Word-Protected Byte Read Serializer

This block answers byte-granular read requests against a storage array whose smallest unit is a 38-bit protected word: 32 data bits and 6 check bits. A request gives a byte address and a byte count. The block never reads a byte from the array on its own. It first fetches the whole word that holds the byte into a local buffer. It then recomputes the check value over the four buffered data bytes and compares it with the stored check bits. If exactly one data bit has flipped, the block repairs that bit in the buffer. Only after this does it shift bytes out serially, one bit per clock, most significant bit first.

Bytes leave in ascending address order, starting at the requested byte. When the stream passes the last byte of a word, the block fetches and corrects the next word before it shifts the first byte of that word. The array sits outside the block and answers one clock after a read strobe. A one-cycle flag reports each word in which a data bit was repaired.

The controller is a single state machine with these states:
- IDLE waits for a request.
- FETCH drives the read strobe for one cycle.
- CAPTURE stores the 38 returned bits in the buffer.
- CORRECT writes the repaired data back into the buffer.
- LOAD moves the current byte into the shifter.
- SHIFT emits eight bits.
- DONE raises the completion pulse.

The transitions are:
- IDLE→FETCH on a request with a nonzero count.
- FETCH→CAPTURE, CAPTURE→CORRECT and CORRECT→LOAD, each unconditional.
- LOAD→SHIFT, unconditional.
- SHIFT→DONE after the eighth bit of the last requested byte.
- SHIFT→FETCH after the eighth bit of byte 3 of a word when more bytes remain.
- SHIFT→LOAD after the eighth bit of any other byte when more bytes remain.
- DONE→IDLE, unconditional.

Top module: `ecc_word_reader`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `busy`, `ser_valid`, `mem_rd_en`, `corr_pulse` and `done` are all low.
- R2: A request with byte address A fetches word A>>2 with a single-cycle `mem_rd_en` strobe. This strobe comes before any `ser_valid` cycle, and `ser_valid` stays low in the cycle that follows the strobe.
- R3: On a word with no errors, the serial stream carries the requested bytes in ascending address order, starting at A, with each byte sent MSB first. Byte b of a word (b = address mod 4) occupies data bits [8b+7:8b].
- R4: A single flipped data bit in a fetched word is repaired before output. For that word, `corr_pulse` is high for exactly one cycle.
- R5: A single flipped check bit leaves the output data equal to the stored data bytes, and `corr_pulse` stays low.
- R6: Once the stream passes byte 4N+3, the next word is fetched and corrected before any bit of byte 4N+4 is shifted. One word fetch occurs per word that the request spans.
- R7: `ser_valid` is high for exactly 8×L cycles for a request of L bytes. It is never high while `busy` is low.
- R8: After the last bit, `done` pulses for one cycle while `busy` is still high. `busy` is low in the next cycle.
- R9: A request made while `busy` is high is ignored: it changes neither the output stream nor the fetch count. A request with a count of zero causes no fetch and no output.
- R10: The array word is {check[5:0], data[31:0]}. Hamming positions 1..38 reserve the powers of two for check bits, and data bits 0..31 fill the remaining positions in ascending order. Check bit k is the XOR of the data bits whose position has bit k set. A syndrome that names a check-bit position, or a position above 38, leaves the data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled in IDLE |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_len | input | LEN_W | Number of bytes to send |
| busy | output | 1 | High from request acceptance through DONE |
| mem_rd_en | output | 1 | Word read strobe to the array |
| mem_rd_addr | output | ADDR_W-2 | Word address for the array |
| mem_rd_data | input | 38 | Word returned one clock after the strobe |
| ser_out | output | 1 | Serial data, MSB first |
| ser_valid | output | 1 | `ser_out` carries a bit |
| corr_pulse | output | 1 | One-cycle flag: a data bit was repaired in this word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench places single flips at chosen positions to hit the interesting cases. A flip in the top data bit and one in the bottom data bit catch a corrector that maps positions wrongly; such a design would send a corrupted byte or miss the pulse. A flip confined to a check bit catches a design that "repairs" data when it should not, which would show up as a wrong byte and a spurious pulse. Requests that cross one or two word boundaries catch a controller that shifts the byte after a boundary from the stale buffer or skips the new fetch; the stream would repeat old bytes and the bit count at the second fetch would be wrong. Requests raised mid-stream and requests with a count of zero catch a controller that restarts or fetches when it should not, which would change the fetch count or the byte stream.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int DATA_W = 32;
    localparam int CHK_W  = 6;
    localparam int WORD_W = DATA_W + CHK_W;
    localparam int NPOS   = WORD_W;

    typedef struct packed {
        logic [CHK_W-1:0]  chk;
        logic [DATA_W-1:0] data;
    } word_t;

    // Hamming position (1..NPOS) taken by data bit idx
    function automatic logic [CHK_W-1:0] data_pos(input int idx);
        int seen;
        logic [CHK_W-1:0] result;
        seen   = 0;
        result = '0;
        for (int p = 1; p <= NPOS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen == idx) result = CHK_W'(p);
                seen++;
            end
        end
        return result;
    endfunction
endpackage

// File: rtl/ecc_check_gen.sv
module ecc_check_gen
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    logic [DATA_W-1:0] col [CHK_W];

    for (genvar k = 0; k < CHK_W; k++) begin : g_col
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            localparam logic [CHK_W-1:0] POS = data_pos(i);
            assign col[k][i] = POS[k] ? data[i] : 1'b0;
        end
        assign chk[k] = ^col[k];
    end
endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector
    import ecc_pkg::*;
(
    input  word_t             raw,
    output logic [DATA_W-1:0] fixed_data,
    output logic              fixed
);
    logic [CHK_W-1:0]  fresh;
    logic [CHK_W-1:0]  syndrome;
    logic [DATA_W-1:0] hit;

    ecc_check_gen u_gen (
        .data (raw.data),
        .chk  (fresh)
    );

    assign syndrome = fresh ^ raw.chk;

    for (genvar i = 0; i < DATA_W; i++) begin : g_hit
        localparam logic [CHK_W-1:0] POS = data_pos(i);
        assign hit[i] = (syndrome == POS);
    end

    assign fixed_data = raw.data ^ hit;
    assign fixed      = |hit;
endmodule

// File: rtl/byte_shifter.sv
module byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sr_q <= '0;
        else if (load)  sr_q <= din;
        else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
    end

    assign msb = sr_q[W-1];
endmodule

// File: rtl/ecc_word_reader.sv
module ecc_word_reader
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [LEN_W-1:0]    req_len,
    output logic                busy,
    output logic                mem_rd_en,
    output logic [ADDR_W-3:0]   mem_rd_addr,
    input  logic [WORD_W-1:0]   mem_rd_data,
    output logic                ser_out,
    output logic                ser_valid,
    output logic                corr_pulse,
    output logic                done
);
    localparam int WA_W  = ADDR_W - 2;
    localparam int BYTES = DATA_W / 8;
    localparam int BI_W  = $clog2(BYTES);

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CAPTURE, S_CORRECT, S_LOAD, S_SHIFT, S_DONE
    } state_t;

    state_t            state_q, state_d;
    logic [WA_W-1:0]   word_q;
    logic [BI_W-1:0]   byte_q;
    logic [LEN_W-1:0]  left_q;
    logic [2:0]        bit_q;
    word_t             buf_q;
    logic [DATA_W-1:0] fixed_data;
    logic              fixed;
    logic [7:0]        cur_byte;
    logic              shift_bit;
    logic              accept;
    logic              last_bit;

    assign accept   = req_valid && (req_len != '0);
    assign last_bit = (bit_q == 3'd7);
    assign cur_byte = buf_q.data[8*byte_q +: 8];

    ecc_corrector u_corr (
        .raw        (buf_q),
        .fixed_data (fixed_data),
        .fixed      (fixed)
    );

    byte_shifter #(.W(8)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state_q == S_LOAD),
        .shift (state_q == S_SHIFT),
        .din   (cur_byte),
        .msb   (shift_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (accept) state_d = S_FETCH;
            S_FETCH:   state_d = S_CAPTURE;
            S_CAPTURE: state_d = S_CORRECT;
            S_CORRECT: state_d = S_LOAD;
            S_LOAD:    state_d = S_SHIFT;
            S_SHIFT: begin
                if (last_bit) begin
                    if (left_q == LEN_W'(1))           state_d = S_DONE;
                    else if (byte_q == BI_W'(BYTES-1)) state_d = S_FETCH;
                    else                               state_d = S_LOAD;
                end
            end
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            byte_q <= '0;
            left_q <= '0;
            bit_q  <= '0;
            buf_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        word_q <= req_addr[ADDR_W-1:2];
                        byte_q <= req_addr[BI_W-1:0];
                        left_q <= req_len;
                    end
                end
                S_CAPTURE: buf_q      <= word_t'(mem_rd_data);
                S_CORRECT: buf_q.data <= fixed_data;
                S_LOAD:    bit_q      <= '0;
                S_SHIFT: begin
                    bit_q <= bit_q + 3'd1;
                    if (last_bit) begin
                        left_q <= left_q - LEN_W'(1);
                        byte_q <= byte_q + BI_W'(1);
                        if (byte_q == BI_W'(BYTES-1)) word_q <= word_q + WA_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != S_IDLE);
        mem_rd_en   = (state_q == S_FETCH);
        mem_rd_addr = word_q;
        ser_valid   = (state_q == S_SHIFT);
        ser_out     = (state_q == S_SHIFT) ? shift_bit : 1'b0;
        corr_pulse  = (state_q == S_CORRECT) && fixed;
        done        = (state_q == S_DONE);
    end
endmodule

// File: rtl/ecc_word_reader_chk.sv
module ecc_word_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic mem_rd_en,
    input logic ser_valid,
    input logic corr_pulse,
    input logic done
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !(busy || mem_rd_en || ser_valid || corr_pulse || done));

    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    a_r2_no_shift_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !ser_valid);

    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        corr_pulse |=> !corr_pulse);

    a_r7_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> busy);

    a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy ##1 (!busy && !done));
endmodule

bind ecc_word_reader ecc_word_reader_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .mem_rd_en  (mem_rd_en),
    .ser_valid  (ser_valid),
    .corr_pulse (corr_pulse),
    .done       (done)
);

// File: tb/ecc_word_reader_tb.sv
module ecc_word_reader_tb;
    localparam int ADDR_W = 10;
    localparam int LEN_W  = 4;
    localparam int NWORDS = 1 << (ADDR_W - 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              busy, mem_rd_en, ser_out, ser_valid, corr_pulse, done;
    logic [ADDR_W-3:0] mem_rd_addr;
    logic [37:0]       mem_rd_data;

    logic [37:0] mem    [NWORDS];
    logic [31:0] golden [NWORDS];

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    ecc_word_reader #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .busy(busy), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .ser_out(ser_out),
        .ser_valid(ser_valid), .corr_pulse(corr_pulse), .done(done)
    );

    // array model: one clock read latency
    always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    // check bits per R10
    function automatic logic [5:0] hamming_chk(input logic [31:0] d);
        logic [5:0] c;
        int di;
        c  = '0;
        di = 0;
        for (int p = 1; p <= 38; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32) begin
                for (int k = 0; k < 6; k++) if (p[k]) c[k] = c[k] ^ d[di];
                di++;
            end
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue one request and compare the stream against golden bytes.
    task automatic run_read(input string req, input int addr, input int len,
                            input int exp_pulses, input bit poke_mid);
        logic [7:0] got [16];
        int bits, fetches, pulses, dones, first_fetch, bits_at_2nd, cyc;
        bit early_shift, finished;
        int exp_fetch;
        bits = 0; fetches = 0; pulses = 0; dones = 0; first_fetch = -1;
        bits_at_2nd = -1; early_shift = 0; finished = 0;
        for (int i = 0; i < 16; i++) got[i] = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = ADDR_W'(addr); req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        for (cyc = 0; cyc < 400 && !finished; cyc++) begin
            if (poke_mid && cyc == 12) begin
                req_valid = 1'b1; req_addr = ADDR_W'(addr + 40); req_len = 4'd1;
            end else begin
                req_valid = 1'b0;
            end
            if (mem_rd_en) begin
                if (fetches == 0) first_fetch = int'(mem_rd_addr);
                if (fetches == 1) bits_at_2nd = bits;
                fetches++;
            end
            if (ser_valid) begin
                if (fetches == 0) early_shift = 1;
                got[bits/8] = {got[bits/8][6:0], ser_out};
                bits++;
            end
            if (corr_pulse) pulses++;
            if (done) begin
                dones++;
                check(busy, "R8", "busy during done", busy, 1);
                finished = 1;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(finished, "R8", "done seen", finished, 1);
        check(!busy && !done, "R8", "idle after done", {busy, done}, 0);
        check(!early_shift && first_fetch == (addr >> 2), "R2", "first fetch word",
              first_fetch, addr >> 2);
        exp_fetch = ((addr + len - 1) >> 2) - (addr >> 2) + 1;
        check(fetches == exp_fetch, "R6", "fetch count", fetches, exp_fetch);
        if (exp_fetch > 1)
            check(bits_at_2nd == 8 * (4 - (addr % 4)), "R6", "bits before 2nd fetch",
                  bits_at_2nd, 8 * (4 - (addr % 4)));
        check(bits == 8 * len, "R7", "serial bit count", bits, 8 * len);
        check(pulses == exp_pulses, (exp_pulses > 0) ? "R4" : "R5", "corr_pulse count",
              pulses, exp_pulses);
        for (int i = 0; i < len; i++) begin
            int a;
            logic [7:0] e;
            a = addr + i;
            e = golden[a >> 2][8*(a % 4) +: 8];
            check(got[i] == e, req, $sformatf("byte @%0d", a), got[i], e);
        end
    endtask

    task automatic t_reset();
        check(!(busy || mem_rd_en || ser_valid || corr_pulse || done), "R1",
              "outputs in reset", {busy, mem_rd_en, ser_valid, corr_pulse, done}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(!(busy || mem_rd_en || ser_valid || corr_pulse || done), "R1",
              "outputs after reset", {busy, mem_rd_en, ser_valid, corr_pulse, done}, 0);
    endtask

    task automatic t_zero_len();
        int seen;
        seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 10'd8; req_len = '0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (busy || mem_rd_en || ser_valid) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R9", "zero-length activity", seen, 0);
    endtask

    initial begin
        for (int w = 0; w < NWORDS; w++) begin
            golden[w] = (32'(w) * 32'h9E3779B9) ^ 32'h5AC3_0F71;
            mem[w]    = {hamming_chk(golden[w]), golden[w]};
        end
        // injected single flips
        mem[3][17] = ~mem[3][17];   // data bit, word 3
        mem[4][35] = ~mem[4][35];   // check bit, word 4
        mem[6][0]  = ~mem[6][0];    // data bit 0, word 6
        mem[9][31] = ~mem[9][31];   // data bit 31, word 9

        t_reset();
        run_read("R3", 5, 3, 0, 0);       // clean, inside one word
        run_read("R4", 12, 4, 1, 0);      // repaired mid-word bit
        run_read("R5", 16, 2, 0, 0);      // check-bit flip only (R10)
        run_read("R6", 22, 5, 1, 0);      // boundary into repaired word
        run_read("R6", 3, 8, 0, 0);       // spans three words
        run_read("R10", 39, 1, 1, 0);     // top data bit repaired
        run_read("R9", 40, 6, 0, 1);      // request while busy ignored
        t_zero_len();
        run_read("R3", 0, 15, 1, 0);      // long stream from byte 0
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule